// File: doc/BRIEF.md
# Interrupt Aggregator with Message Doorbell

This block gathers 64 interrupt sources into one active-high request line for a parent interrupt controller. The low source indices come from wired, level-high inputs. The remaining indices are message-signalled. An agent raises one of these by writing the source number to a doorbell register. Each source has a pending bit and a mask bit. The summary line is the registered OR of every pending bit whose mask is clear.

Software uses a single-cycle register port with address, write data, write enable and combinational read data. Pending bits are held in two 32-bit cause banks, and source n is bit n mod 32 of bank n div 32. Writing a one to a cause bit clears it. The two mask banks are plain read/write registers, so software can read a mask, modify it and write it back. Reset leaves every source idle and disabled.

Top module: `irq_merge_unit`

## Requirements
- R1: Source n is held as bit (n mod 32) of bank (n div 32). A read at offset 0x00 returns pending bits of sources 0..31, and a read at offset 0x04 returns sources 32..63.
- R2: A write to offset 0x00 or 0x04 clears every pending bit of that bank whose data bit is 1. Bits written 0 keep their state.
- R3: Offsets 0x20 (sources 0..31) and 0x24 (sources 32..63) are mask registers that read back the last value written. A mask bit of 1 keeps its source from the summary output.
- R4: A write to offset 0x30 whose data value v satisfies 21 <= v <= 63 sets the pending bit of source v on the next clock.
- R5: A doorbell write whose value is below 21 or at least 64 changes no pending bit. The full 32-bit value is compared, not its low bits.
- R6: Sources 0..20 follow wired inputs at level. Each cycle an input is high, its pending bit is set on the next clock. When a clear and a high input meet in the same cycle, the bit stays set.
- R7: Reset (synchronous, active high) makes all pending bits 0, all mask bits 1 and the summary output 0.
- R8: The summary output equals, one clock later, the OR over all sources of (pending AND NOT mask).
- R9: Writes to any offset other than 0x00, 0x04, 0x20, 0x24 and 0x30 change nothing. Reads of any offset other than the four cause and mask offsets return zero.
- R10: Writing all ones to both cause and both mask registers leaves every source cleared and disabled while the wired inputs are low.
- R11: A pending bit falls only in the cycle after a cause write carrying a 1 in its position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| wired_in | input | 21 | Level-high wired sources 0..20 |
| irq_out | output | 1 | Registered summary request |

## Verification
Doorbell writes are tried at the first message index, the last one, and one inside the upper bank. This separates bank selection from bit position. The ignored doorbell values cover a wired index, the first value past the range, and a wide value whose low six bits name a valid source. The last case exposes a decoder that truncates before comparing. Wired inputs are held high across a clear, then dropped before a clear, which tells set-wins priority apart from plain clearing. Mask patterns that enable only one pending source show whether the summary tracks the masked OR with exactly one cycle of lag.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;

    localparam int IM_NUM_SRC    = 64;
    localparam int IM_BANK_W     = 32;
    localparam int IM_NUM_BANKS  = IM_NUM_SRC / IM_BANK_W;
    localparam int IM_NUM_WIRED  = 21;
    localparam int IM_ADDR_W     = 8;
    localparam int IM_DATA_W     = IM_BANK_W;
    localparam int IM_SRC_IDX_W  = $clog2(IM_NUM_SRC);
    localparam int IM_BANK_IDX_W = (IM_NUM_BANKS > 1) ? $clog2(IM_NUM_BANKS) : 1;

    localparam logic [IM_ADDR_W-1:0] OFS_CAUSE = 8'h00;
    localparam logic [IM_ADDR_W-1:0] OFS_MASK  = 8'h20;
    localparam logic [IM_ADDR_W-1:0] OFS_DOOR  = 8'h30;

    typedef enum logic [1:0] {
        RSEL_NONE  = 2'd0,
        RSEL_CAUSE = 2'd1,
        RSEL_MASK  = 2'd2
    } rsel_kind_e;

    typedef struct packed {
        rsel_kind_e                 kind;
        logic [IM_BANK_IDX_W-1:0]   bank;
    } rsel_t;

    typedef struct packed {
        logic [IM_NUM_SRC-1:0]      clr;
        logic [IM_NUM_BANKS-1:0]    mask_we;
        logic                       door_ok;
        logic [IM_SRC_IDX_W-1:0]    door_idx;
    } wr_cmd_t;

    // Offset of a cause bank: banks are 4 bytes apart
    function automatic logic [IM_ADDR_W-1:0] cause_ofs(input int bank);
        return OFS_CAUSE + IM_ADDR_W'(4 * bank);
    endfunction

    function automatic logic [IM_ADDR_W-1:0] mask_ofs(input int bank);
        return OFS_MASK + IM_ADDR_W'(4 * bank);
    endfunction

    // Doorbell values must name a message-signalled source
    function automatic logic door_value_ok(input logic [IM_DATA_W-1:0] v);
        return (v >= IM_DATA_W'(IM_NUM_WIRED)) && (v < IM_DATA_W'(IM_NUM_SRC));
    endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_merge_pkg::*;
(
    input  logic [IM_ADDR_W-1:0] addr,
    input  logic [IM_DATA_W-1:0] wdata,
    input  logic                 we,
    output wr_cmd_t              cmd,
    output rsel_t                rsel
);

    always_comb begin
        cmd       = '0;
        rsel.kind = RSEL_NONE;
        rsel.bank = '0;
        for (int b = 0; b < IM_NUM_BANKS; b++) begin
            if (addr == cause_ofs(b)) begin
                rsel.kind = RSEL_CAUSE;
                rsel.bank = IM_BANK_IDX_W'(b);
                if (we) begin
                    cmd.clr[b*IM_BANK_W +: IM_BANK_W] = wdata[IM_BANK_W-1:0];
                end
            end
            if (addr == mask_ofs(b)) begin
                rsel.kind = RSEL_MASK;
                rsel.bank = IM_BANK_IDX_W'(b);
                cmd.mask_we[b] = we;
            end
        end
        if (we && (addr == OFS_DOOR) && door_value_ok(wdata)) begin
            cmd.door_ok  = 1'b1;
            cmd.door_idx = wdata[IM_SRC_IDX_W-1:0];
        end
    end

endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import irq_merge_pkg::*;
#(
    parameter int BANK_W = IM_BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] set_vec,
    input  logic [BANK_W-1:0] clr_vec,
    input  logic              mask_we,
    input  logic [BANK_W-1:0] mask_wdata,
    output logic [BANK_W-1:0] pend_q,
    output logic [BANK_W-1:0] mask_q,
    output logic              any_active
);

    logic [BANK_W-1:0] pend_d;

    // A set arriving in the clearing cycle wins
    always_comb begin
        pend_d = (pend_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            mask_q <= '1;
        end else begin
            pend_q <= pend_d;
            if (mask_we) begin
                mask_q <= mask_wdata;
            end
        end
    end

    always_comb begin
        any_active = |(pend_q & ~mask_q);
    end

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import irq_merge_pkg::*;
(
    input  rsel_t                 rsel,
    input  logic [IM_NUM_SRC-1:0] pend_all,
    input  logic [IM_NUM_SRC-1:0] mask_all,
    output logic [IM_DATA_W-1:0]  rdata
);

    always_comb begin
        unique case (rsel.kind)
            RSEL_CAUSE: rdata = pend_all[rsel.bank*IM_BANK_W +: IM_BANK_W];
            RSEL_MASK:  rdata = mask_all[rsel.bank*IM_BANK_W +: IM_BANK_W];
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_merge_unit.sv
module irq_merge_unit
    import irq_merge_pkg::*;
#(
    parameter int NUM_WIRED = IM_NUM_WIRED
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [IM_ADDR_W-1:0]  reg_addr,
    input  logic [IM_DATA_W-1:0]  reg_wdata,
    input  logic                  reg_we,
    output logic [IM_DATA_W-1:0]  reg_rdata,
    input  logic [NUM_WIRED-1:0]  wired_in,
    output logic                  irq_out
);

    wr_cmd_t                  cmd;
    rsel_t                    rsel;
    logic [IM_NUM_SRC-1:0]    set_vec;
    logic [IM_NUM_SRC-1:0]    pend_all;
    logic [IM_NUM_SRC-1:0]    mask_all;
    logic [IM_NUM_BANKS-1:0]  bank_active;
    logic                     irq_q;

    irq_reg_decode u_decode (
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .we    (reg_we),
        .cmd   (cmd),
        .rsel  (rsel)
    );

    // Per-source set: level input for wired sources, doorbell hit otherwise
    for (genvar n = 0; n < IM_NUM_SRC; n++) begin : g_src
        if (n < NUM_WIRED) begin : g_wired
            assign set_vec[n] = wired_in[n];
        end else begin : g_msg
            assign set_vec[n] = cmd.door_ok &&
                                (cmd.door_idx == IM_SRC_IDX_W'(n));
        end
    end

    for (genvar b = 0; b < IM_NUM_BANKS; b++) begin : g_bank
        irq_src_bank #(.BANK_W(IM_BANK_W)) u_bank (
            .clk        (clk),
            .rst        (rst),
            .set_vec    (set_vec[b*IM_BANK_W +: IM_BANK_W]),
            .clr_vec    (cmd.clr[b*IM_BANK_W +: IM_BANK_W]),
            .mask_we    (cmd.mask_we[b]),
            .mask_wdata (reg_wdata[IM_BANK_W-1:0]),
            .pend_q     (pend_all[b*IM_BANK_W +: IM_BANK_W]),
            .mask_q     (mask_all[b*IM_BANK_W +: IM_BANK_W]),
            .any_active (bank_active[b])
        );
    end

    irq_read_mux u_rmux (
        .rsel     (rsel),
        .pend_all (pend_all),
        .mask_all (mask_all),
        .rdata    (reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |bank_active;
        end
    end

    assign irq_out = irq_q;

endmodule

// File: rtl/irq_merge_chk.sv
module irq_merge_chk
    import irq_merge_pkg::*;
#(
    parameter int NUM_WIRED = IM_NUM_WIRED
) (
    input logic                  clk,
    input logic                  rst,
    input logic [IM_ADDR_W-1:0]  reg_addr,
    input logic [IM_DATA_W-1:0]  reg_wdata,
    input logic                  reg_we,
    input logic [IM_DATA_W-1:0]  reg_rdata,
    input logic [NUM_WIRED-1:0]  wired_in,
    input logic                  irq_out,
    input logic [IM_NUM_SRC-1:0] pend_all,
    input logic [IM_NUM_SRC-1:0] mask_all
);

    logic [IM_NUM_SRC-1:0] w1c_seen;
    logic                  readable;
    logic                  door_good;

    always_comb begin
        w1c_seen = '0;
        if (reg_we && reg_addr == 8'h00) w1c_seen[31:0]  = reg_wdata;
        if (reg_we && reg_addr == 8'h04) w1c_seen[63:32] = reg_wdata;
        readable  = (reg_addr == 8'h00) || (reg_addr == 8'h04) ||
                    (reg_addr == 8'h20) || (reg_addr == 8'h24);
        door_good = (reg_wdata >= 32'd21) && (reg_wdata <= 32'd63);
    end

    // R3
    mask_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 8'h20) |=> (mask_all[31:0] == $past(reg_wdata)));

    // R4
    door_set_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 8'h30 && door_good) |=> pend_all[$past(reg_wdata[5:0])]);

    // R5
    door_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 8'h30 && !door_good) |=>
            (((pend_all & ~$past(pend_all)) >> NUM_WIRED) == '0));

    // R6
    wired_set_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_all[NUM_WIRED-1:0] & $past(wired_in)) == $past(wired_in)));

    // R8
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out == $past(|(pend_all & ~mask_all))));

    // R9
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        !readable |-> (reg_rdata == '0));

    // R11
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(pend_all) & ~pend_all) & ~$past(w1c_seen)) == '0));

endmodule

bind irq_merge_unit irq_merge_chk #(.NUM_WIRED(NUM_WIRED)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata),
    .wired_in  (wired_in),
    .irq_out   (irq_out),
    .pend_all  (pend_all),
    .mask_all  (mask_all)
);

// File: tb/irq_merge_unit_bench.sv
`timescale 1ns/1ps
module irq_merge_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = 32'h0;
    logic        we = 1'b0;
    logic [20:0] wired = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state
    logic [63:0] m_pend;
    logic [63:0] m_mask;
    logic        m_irq;

    always #4 clk = ~clk;

    irq_merge_unit u_irq_merge_unit (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (addr),
        .reg_wdata (wdata),
        .reg_we    (we),
        .reg_rdata (rdata),
        .wired_in  (wired),
        .irq_out   (irq)
    );

    // Behavioural model, updated on each rising edge
    always @(posedge clk) begin
        logic [63:0] nxt;
        if (rst) begin
            m_pend = '0;
            m_mask = '1;
            m_irq  = 1'b0;
        end else begin
            m_irq = |(m_pend & ~m_mask);
            nxt = m_pend;
            if (we) begin
                case (addr)
                    8'h00: nxt[31:0]  = nxt[31:0]  & ~wdata;
                    8'h04: nxt[63:32] = nxt[63:32] & ~wdata;
                    8'h20: m_mask[31:0]  = wdata;
                    8'h24: m_mask[63:32] = wdata;
                    8'h30: if (wdata >= 21 && wdata < 64) nxt[wdata[5:0]] = 1'b1;
                    default: ;
                endcase
            end
            for (int i = 0; i < 21; i++) if (wired[i]) nxt[i] = 1'b1;
            m_pend = nxt;
        end
    end

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00:   return m_pend[31:0];
            8'h04:   return m_pend[63:32];
            8'h20:   return m_mask[31:0];
            8'h24:   return m_mask[63:32];
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the edge
    always @(negedge clk) begin
        #2;
        if (!rst && !done) begin
            check("R8 per-cycle summary", {31'b0, irq}, {31'b0, m_irq});
            check("R1 per-cycle read", rdata, model_read(addr));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            we = 1'b0;
        end
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a; we = 1'b0;
        #2;
        check(tag, rdata, exp);
    endtask

    task automatic irq_chk(input logic exp, input string tag);
        @(negedge clk);
        we = 1'b0;
        #2;
        check(tag, {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic set_wired(input logic [20:0] v);
        @(negedge clk);
        wired = v; we = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R7 reset state
        rd_chk(8'h00, 32'h0, "R7 cause0 after reset");
        rd_chk(8'h04, 32'h0, "R7 cause1 after reset");
        rd_chk(8'h20, 32'hFFFF_FFFF, "R7 mask0 after reset");
        rd_chk(8'h24, 32'hFFFF_FFFF, "R7 mask1 after reset");
        irq_chk(1'b0, "R7 summary after reset");

        // R4 doorbell sets, R1 bank mapping
        wr(8'h30, 32'd21);
        rd_chk(8'h00, 32'h0020_0000, "R4 doorbell first message index");
        wr(8'h30, 32'd63);
        rd_chk(8'h04, 32'h8000_0000, "R1 source 63 in bank1 bit31");
        wr(8'h30, 32'd40);
        rd_chk(8'h04, 32'h8000_0100, "R1 source 40 in bank1 bit8");

        // R5 ignored doorbell values
        wr(8'h30, 32'd5);
        wr(8'h30, 32'd64);
        wr(8'h30, 32'd286);
        rd_chk(8'h00, 32'h0020_0000, "R5 bank0 unchanged by bad doorbell");
        rd_chk(8'h04, 32'h8000_0100, "R5 bank1 unchanged by bad doorbell");
        irq_chk(1'b0, "R3 all masked keeps summary low");

        // R3 mask write, R8 summary lag
        wr(8'h24, 32'hFFFF_FEFF);
        rd_chk(8'h24, 32'hFFFF_FEFF, "R3 mask1 readback");
        irq_chk(1'b1, "R8 summary after unmasking source 40");

        // R2 write-one-to-clear
        wr(8'h04, 32'h0);
        rd_chk(8'h04, 32'h8000_0100, "R2 zero write keeps pending");
        wr(8'h04, 32'h0000_0100);
        rd_chk(8'h04, 32'h8000_0000, "R2 one clears only its bit");
        irq_chk(1'b0, "R8 summary drops after clear");

        // R6 wired level and set-wins
        set_wired(21'h8);
        rd_chk(8'h00, 32'h0020_0008, "R6 wired input sets pending");
        wr(8'h00, 32'h8);
        rd_chk(8'h00, 32'h0020_0008, "R6 set wins over clear");
        set_wired(21'h0);
        wr(8'h00, 32'h8);
        rd_chk(8'h00, 32'h0020_0000, "R6 clear after input low");

        // R9 unmapped offsets
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h28, 32'h0);
        rd_chk(8'h10, 32'h0, "R9 unmapped read zero");
        rd_chk(8'h30, 32'h0, "R9 doorbell reads zero");
        rd_chk(8'h20, 32'hFFFF_FFFF, "R9 mask0 untouched");
        rd_chk(8'h00, 32'h0020_0000, "R9 cause0 untouched");

        // R8 summary from bank0
        wr(8'h20, 32'hFFDF_FFFF);
        idle(1);
        irq_chk(1'b1, "R8 summary from source 21");
        // R11 pending holds without clear
        idle(10);
        rd_chk(8'h00, 32'h0020_0000, "R11 pending held");

        // R10 all-ones initialization
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);
        rd_chk(8'h00, 32'h0, "R10 cause0 cleared");
        rd_chk(8'h04, 32'h0, "R10 cause1 cleared");
        rd_chk(8'h20, 32'hFFFF_FFFF, "R10 mask0 set");
        rd_chk(8'h24, 32'hFFFF_FFFF, "R10 mask1 set");
        irq_chk(1'b0, "R10 summary low");

        // All wired high, all unmasked
        set_wired(21'h1F_FFFF);
        wr(8'h20, 32'h0);
        rd_chk(8'h00, 32'h001F_FFFF, "R6 all wired inputs pending");
        irq_chk(1'b1, "R8 summary with wired sources");

        // R7 reset mid-run
        set_wired(21'h0);
        @(negedge clk);
        rst = 1'b1;
        idle(2);
        @(negedge clk);
        rst = 1'b0;
        rd_chk(8'h00, 32'h0, "R7 cause0 after second reset");
        rd_chk(8'h20, 32'hFFFF_FFFF, "R7 mask0 after second reset");
        irq_chk(1'b0, "R7 summary after second reset");

        idle(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule